// File: doc/BRIEF.md
# DSP-to-Host Interrupt Collector

This block collects interrupt requests that a DSP core raises toward its host. Each of the `NSRC` request lines sets a sticky bit in a pending register. The host can read that register at any time. A control enable bit gates the combined condition "some bit is pending". The gated condition drives one host interrupt pin. That pin can be set up as active-high or active-low, and as a level or a single-cycle pulse.

The host services an interrupt in a fixed order:
- It clears the enable bit.
- It reads the pending register.
- It writes back the bitwise complement of what it read. A zero clears a bit and a one leaves it untouched.
- It sets the enable bit again.

A request that arrives during this window stays pending. A request that arrives in the same cycle as a clear of its own bit also stays pending, because a set wins over a clear.

A three-state shaper drives the pin:
- `SH_IDLE` moves to `SH_PULSE` when the gated condition is true.
- `SH_PULSE` moves to `SH_HOLD` if the condition holds, and back to `SH_IDLE` if it drops.
- `SH_HOLD` stays while the condition holds and returns to `SH_IDLE` when it drops.

In level mode the pin is active in `SH_PULSE` and `SH_HOLD`. In pulse mode it is active only in `SH_PULSE`. The pin therefore follows the gated condition with one register stage of delay.

Top module: `dsp_host_irq`

## Requirements
- R1: After reset the pending register reads zero, the enable readback is 0 and the interrupt pin is at its inactive level.
- R2: A request bit that is high at a clock edge sets the matching pending bit, which is visible on `host_pend` after that edge and stays set until cleared.
- R3: A clear write removes every pending bit whose `host_clr_wdata` bit is 0 and leaves bits written as 1 unchanged.
- R4: A request bit that is high in the same cycle as a clear write of that bit leaves the bit pending.
- R5: While the enable bit is 0 the pin stays inactive, whatever is pending.
- R6: In level mode (`cfg_pulse`=0) the pin is active one cycle after "any pending and enabled" becomes true, stays active while it holds, and goes inactive one cycle after it becomes false.
- R7: In pulse mode (`cfg_pulse`=1) the pin is active for exactly one cycle, one cycle after each rising edge of "any pending and enabled".
- R8: With `cfg_active_low`=1 the active pin level is 0 and the inactive level is 1; with 0 the active level is 1.
- R9: A request taken while the enable bit is 0 stays pending and drives the pin once the enable bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_irq_req | input | NSRC | Request bits from the DSP, sampled each edge |
| host_en_we | input | 1 | Write strobe for the enable bit |
| host_en_wdata | input | 1 | New enable value |
| host_clr_we | input | 1 | Write strobe for the pending clear mask |
| host_clr_wdata | input | NSRC | Clear mask: 0 clears the bit, 1 keeps it |
| cfg_active_low | input | 1 | Pin polarity select |
| cfg_pulse | input | 1 | Pin shape select: 0 level, 1 pulse |
| host_pend | output | NSRC | Pending register contents |
| host_en | output | 1 | Enable bit readback |
| host_irq | output | 1 | Shaped host interrupt pin |

## Verification
The bench raises a request in the same cycle that its bit is cleared. A design that let the clear win would drop that bit, and the bench would see a pending value one bit short.

It clears a subset of bits with a partial mask. A design that treated the written ones as the bits to clear would leave the wrong bits behind.

It raises a source while the enable bit is low and holds it across several cycles. A leaky gate would show up as an early pin assertion. A design that discarded requests while disabled would never assert the pin after the enable is set again.

In pulse mode it checks that the pin stays active for one cycle only while the condition persists, and that it fires again after a full clear and a new request. It also checks that both polarities give the expected idle and active levels.

// File: rtl/dhi_pkg.sv
package dhi_pkg;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_PULSE = 2'd1,
        SH_HOLD  = 2'd2
    } shape_state_e;
endpackage

// File: rtl/dhi_pend_reg.sv
module dhi_pend_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_keep_i,
    output logic [W-1:0] pend_o,
    output logic         any_o
);
    logic [W-1:0] pend_q;

    // One sticky cell per source; a new set overrides a same-cycle clear.
    for (genvar b = 0; b < W; b++) begin : g_cell
        logic drop;
        assign drop = clr_we_i & ~clr_keep_i[b];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q[b] <= 1'b0;
            else if (set_i[b])
                pend_q[b] <= 1'b1;
            else if (drop)
                pend_q[b] <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign any_o  = |pend_q;

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i) |=> ((pend_q & $past(pend_q | set_i)) == $past(pend_q | set_i)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((pend_q & ~$past(clr_keep_i) & ~$past(set_i)) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dhi_gate.sv
module dhi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_we_i,
    input  logic en_wd_i,
    input  logic any_i,
    output logic en_o,
    output logic cond_o
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_we_i)
            en_q <= en_wd_i;
    end

    assign en_o   = en_q;
    assign cond_o = en_q & any_i;

    assert_en_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> (en_q == $past(en_wd_i)));
endmodule

// File: rtl/dhi_shaper.sv
module dhi_shaper
    import dhi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic pulse_mode_i,
    input  logic active_low_i,
    output logic active_o,
    output logic pin_o
);
    shape_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= SH_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_IDLE:  st_d = cond_i ? SH_PULSE : SH_IDLE;
            SH_PULSE: st_d = cond_i ? SH_HOLD  : SH_IDLE;
            SH_HOLD:  st_d = cond_i ? SH_HOLD  : SH_IDLE;
            default:  st_d = SH_IDLE;
        endcase
    end

    always_comb begin
        active_o = 1'b0;
        unique case (st_q)
            SH_IDLE:  active_o = 1'b0;
            SH_PULSE: active_o = 1'b1;
            SH_HOLD:  active_o = !pulse_mode_i;
            default:  active_o = 1'b0;
        endcase
        pin_o = active_o ^ active_low_i;
    end

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && !pulse_mode_i) |=> active_o);

    assert_level_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_i) |=> !active_o);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SH_PULSE) |=> (st_q != SH_PULSE));
endmodule

// File: rtl/dsp_host_irq.sv
module dsp_host_irq #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] dsp_irq_req,
    input  logic            host_en_we,
    input  logic            host_en_wdata,
    input  logic            host_clr_we,
    input  logic [NSRC-1:0] host_clr_wdata,
    input  logic            cfg_active_low,
    input  logic            cfg_pulse,
    output logic [NSRC-1:0] host_pend,
    output logic            host_en,
    output logic            host_irq
);
    logic any_pend;
    logic gated;
    logic irq_active;

    dhi_pend_reg #(.W(NSRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (dsp_irq_req),
        .clr_we_i   (host_clr_we),
        .clr_keep_i (host_clr_wdata),
        .pend_o     (host_pend),
        .any_o      (any_pend)
    );

    dhi_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we_i (host_en_we),
        .en_wd_i (host_en_wdata),
        .any_i   (any_pend),
        .en_o    (host_en),
        .cond_o  (gated)
    );

    dhi_shaper u_shape (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond_i       (gated),
        .pulse_mode_i (cfg_pulse),
        .active_low_i (cfg_active_low),
        .active_o     (irq_active),
        .pin_o        (host_irq)
    );

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_en) |=> !irq_active);

    assert_held_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_en && !host_clr_we && (host_pend != '0)) |=> (host_pend != '0));
endmodule

// File: tb/dsp_host_irq_tb.sv
module dsp_host_irq_tb;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] pend;
        logic         en;
        logic         pin;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] req = '0;
    logic en_we = 1'b0, en_wd = 1'b0, clr_we = 1'b0;
    logic [W-1:0] clr_wd = '1;
    logic act_low = 1'b0, pulse = 1'b0;
    logic [W-1:0] pend;
    logic en_rb, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    // reference state
    logic [W-1:0] m_pend = '0;
    logic m_en = 1'b0, c1 = 1'b0, c2 = 1'b0;

    always #10 clk = ~clk;

    dsp_host_irq #(.NSRC(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .dsp_irq_req(req),
        .host_en_we(en_we), .host_en_wdata(en_wd),
        .host_clr_we(clr_we), .host_clr_wdata(clr_wd),
        .cfg_active_low(act_low), .cfg_pulse(pulse),
        .host_pend(pend), .host_en(en_rb), .host_irq(irq)
    );

    task automatic step(input logic [W-1:0] s, input logic cw, input logic [W-1:0] cd,
                        input logic ew, input logic ed, input string tag);
        exp_t e;
        logic cond_old;
        logic act;
        @(negedge clk);
        req = s; clr_we = cw; clr_wd = cd; en_we = ew; en_wd = ed;
        @(posedge clk);
        #1;
        cond_old = (|m_pend) & m_en;
        c2 = c1;
        c1 = cond_old;
        for (int b = 0; b < W; b++) begin
            if (s[b]) m_pend[b] = 1'b1;
            else if (cw && !cd[b]) m_pend[b] = 1'b0;
        end
        if (ew) m_en = ed;
        act = pulse ? (c1 & ~c2) : c1;
        e.pend = m_pend; e.en = m_en; e.pin = act ^ act_low; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step('0, 1'b0, '1, 1'b0, 1'b0, tag);
    endtask

    task automatic clear(input logic [W-1:0] keep, input string tag);
        step('0, 1'b1, keep, 1'b0, 1'b0, tag);
    endtask

    task automatic set_en(input logic v, input string tag);
        step('0, 1'b0, '1, 1'b1, v, tag);
    endtask

    // monitor: compare after each edge, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pend !== e.pend) begin
                    errors++;
                    $display("FAIL %s pend actual=%h expected=%h", e.tag, pend, e.pend);
                end
                checks++;
                if (irq !== e.pin) begin
                    errors++;
                    $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.pin);
                end
                checks++;
                if (en_rb !== e.en) begin
                    errors++;
                    $display("FAIL %s en actual=%b expected=%b", e.tag, en_rb, e.en);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (pend !== '0 || irq !== 1'b0 || en_rb !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset pend=%h irq=%b en=%b expected 0/0/0", pend, irq, en_rb);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");

        // level mode, active high
        set_en(1'b1, "R6 enable");
        step(16'h0005, 1'b0, '1, 1'b0, 1'b0, "R2 set 0005");
        idle("R6 level rises");
        step(16'h0100, 1'b0, '1, 1'b0, 1'b0, "R2 set 0100 sticky");
        idle("R6 level held");
        clear(~16'h0105, "R3 full clear");
        idle("R6 level drops");
        step(16'h00F0, 1'b0, '1, 1'b0, 1'b0, "R2 set 00F0");
        clear(16'hFFBF, "R3 partial clear bit6");
        step(16'h0010, 1'b1, 16'hFFEF, 1'b0, 1'b0, "R4 set wins over clear");
        step(16'h0001, 1'b1, 16'hFF7F, 1'b0, 1'b0, "R4 set plus clear other bit");
        clear(16'h0000, "R3 clear all");
        idle("R6 idle");

        // service window with enable off
        set_en(1'b0, "R5 disable");
        step(16'h8000, 1'b0, '1, 1'b0, 1'b0, "R9 request while disabled");
        idle("R5 no pin while disabled");
        idle("R5 no pin while disabled 2");
        step(16'h0000, 1'b0, '1, 1'b1, 1'b1, "R9 re-enable");
        idle("R9 pin after re-enable");
        clear(16'h7FFF, "R3 clear bit15");
        idle("R6 drop after clear");

        // pulse mode
        @(negedge clk); pulse = 1'b1;
        idle("R7 mode switch");
        step(16'h0002, 1'b0, '1, 1'b0, 1'b0, "R7 set 0002");
        idle("R7 pulse cycle");
        idle("R7 no repeat while held");
        step(16'h0004, 1'b0, '1, 1'b0, 1'b0, "R7 new bit no repeat");
        idle("R7 still quiet");
        clear(16'h0000, "R7 clear");
        idle("R7 condition low");
        step(16'h0008, 1'b0, '1, 1'b0, 1'b0, "R7 second request");
        idle("R7 second pulse");
        idle("R7 second pulse ends");
        clear(16'h0000, "R7 clear again");
        idle("R7 quiet");

        // active low, level mode
        @(negedge clk); pulse = 1'b0; act_low = 1'b1;
        idle("R8 idle level high");
        step(16'h4000, 1'b0, '1, 1'b0, 1'b0, "R8 set 4000");
        idle("R8 active low");
        idle("R8 active low held");
        clear(16'h0000, "R8 clear");
        idle("R8 back high");

        // active low, pulse mode
        @(negedge clk); pulse = 1'b1;
        idle("R8 pulse idle");
        step(16'h0040, 1'b0, '1, 1'b0, 1'b0, "R8 pulse set");
        idle("R8 low pulse");
        idle("R8 pulse over");

        repeat (2) @(posedge clk);
        #8;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule